// File: doc/BRIEF.md
# Programmable Taint Rule Unit

This block holds the per-instruction tag logic of a processor core in which every register and every memory word carries a small tag vector, one bit for each independent security policy. The pipeline presents each decoded primitive operation with its operation class, the tags of its two source operands, the tag of its address (or jump target) and the tag of the memory word involved. For every policy the unit then decides two things: the tag bit written to the destination, and whether the operation must raise a trap for that policy.

Software programs the decision for each policy through two configuration registers. The check register selects, per operation class, whether a tainted address and/or a tainted operand raises a trap. The propagate register selects, per class, which tag terms flow into the destination and whether they are combined by AND or by OR. All policies are evaluated in parallel and independently, so several protections (for example pointer checks, string tracking and system-call interposition) can run at once. Results appear one clock after the operation together with its program counter.

Top module: `taint_rule_unit`

## Requirements
- R1: After reset every check and propagate register is zero, so any operation, whatever its tags, yields destination tag 0 and no trap; all outputs are 0 while reset is held.
- R2: A configuration write (cfg_we=1) stores cfg_data into the register of policy cfg_pol selected by cfg_kind (0 = check register, using cfg_data[17:0]; 1 = propagate register, using cfg_data[26:0]); it governs operations presented from the next cycle on, and an operation presented in the same cycle as the write is judged by the old contents.
- R3: Operation class codes are 0 arithmetic, 1 move, 2 logical, 3 compare, 4 instruction fetch, 5 load, 6 store, 7 jump/branch (address tag carries the target tag, source A the condition tag), 8 system call (sources carry the argument tags).
- R4: In the check register, bit 2c enables a trap when the address tag is set and bit 2c+1 enables a trap when the operand term is set, for class c; both may be enabled together. For the check, the operand term is the memory tag for classes 4 and 5 and the OR of both source tags otherwise.
- R5: In the propagate register, bits [3c+1:3c] give the mode for class c (0 none, 1 address only, 2 operand only, 3 both) and bit 3c+2 selects AND combining (1) instead of OR (0).
- R6: For propagation, the operand term is the memory tag for classes 4 and 5; for other classes it is the AND of the two source tags when the AND bit is set and their OR otherwise.
- R7: The destination tag bit is 0 in mode none, the address tag in address mode, the operand term in operand mode, and in both mode the address tag combined with the operand term by AND or OR as selected.
- R8: Each policy bit uses only its own registers and its own bit of each input tag; trap and destination bits of different policies are independent.
- R9: Results are registered: an operation with op_vld=1 at a clock edge yields out_vld=1, its destination tag, its trap vector and out_pc equal to its op_pc right after that edge; with op_vld=0 all outputs are 0 after the edge.
- R10: A class code of 9 or above produces destination tag 0 and no trap for every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pol | input | 2 | Policy whose register is written |
| cfg_kind | input | 1 | 0 = check register, 1 = propagate register |
| cfg_data | input | 27 | Value written |
| op_vld | input | 1 | A primitive operation is presented |
| op_class | input | 4 | Operation class code |
| op_pc | input | 32 | Program counter of the operation |
| src_a_tag | input | 4 | Tag of source operand A |
| src_b_tag | input | 4 | Tag of source operand B |
| addr_tag | input | 4 | Tag of the address or jump target |
| mem_tag | input | 4 | Tag of the memory word accessed |
| out_vld | output | 1 | Result valid |
| out_dst_tag | output | 4 | Destination tag |
| out_trap | output | 4 | Per-policy trap request |
| out_pc | output | 32 | Program counter of the judged operation |

## Verification
Every operation's destination tag, trap vector and program counter are due exactly one clock edge after it is presented, and a configuration write takes effect for the operation presented one cycle later. The bench drives each operation on the falling edge, computes its expected result from a shadow copy of the configuration as it stood before any write in that same cycle, and compares shortly after the following rising edge, then applies the write to the shadow. This ordering also checks directly that a same-cycle write does not affect the operation beside it.

// File: rtl/taint_pkg.sv
package taint_pkg;
    localparam int NCLASS = 9;
    localparam int CLS_W  = 4;

    typedef enum logic [CLS_W-1:0] {
        OPC_ARITH   = 4'd0,
        OPC_MOVE    = 4'd1,
        OPC_LOGIC   = 4'd2,
        OPC_CMP     = 4'd3,
        OPC_FETCH   = 4'd4,
        OPC_LOAD    = 4'd5,
        OPC_STORE   = 4'd6,
        OPC_CTRL    = 4'd7,
        OPC_SYSCALL = 4'd8
    } op_class_e;

    localparam int CHK_FLD  = 2;
    localparam int PROP_FLD = 3;
    localparam int CHK_W    = CHK_FLD * NCLASS;
    localparam int PROP_W   = PROP_FLD * NCLASS;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_ADDR = 2'd1,
        PM_OPND = 2'd2,
        PM_BOTH = 2'd3
    } prop_mode_e;
endpackage

// File: rtl/taint_cfg_regs.sv
module taint_cfg_regs
    import taint_pkg::*;
#(
    parameter int NPOL  = 4,
    localparam int POL_W = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [POL_W-1:0]            cfg_pol,
    input  logic                        cfg_kind,
    input  logic [PROP_W-1:0]           cfg_data,
    output logic [NPOL-1:0][CHK_W-1:0]  chk_o,
    output logic [NPOL-1:0][PROP_W-1:0] prop_o
);
    typedef struct packed {
        logic [NPOL-1:0][CHK_W-1:0]  chk;
        logic [NPOL-1:0][PROP_W-1:0] prop;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int p = 0; p < NPOL; p++) begin
            if (cfg_we && (cfg_pol == POL_W'(p))) begin
                if (cfg_kind)
                    cfg_d.prop[p] = cfg_data;
                else
                    cfg_d.chk[p] = cfg_data[CHK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign chk_o  = cfg_q.chk;
    assign prop_o = cfg_q.prop;

    for (genvar gp = 0; gp < NPOL; gp++) begin : g_chk_asrt
        // R2: a write reaches the selected register on the next edge
        a_r2_chk_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_kind && cfg_pol == POL_W'(gp))
            |=> chk_o[gp] == $past(cfg_data[CHK_W-1:0]));
        a_r2_prop_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_kind && cfg_pol == POL_W'(gp))
            |=> prop_o[gp] == $past(cfg_data));
        // R2: registers of a policy not written keep their value
        a_r2_unwritten_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_pol == POL_W'(gp))
            |=> ($stable(chk_o[gp]) && $stable(prop_o[gp])));
    end
endmodule

// File: rtl/taint_rule_eval.sv
module taint_rule_eval
    import taint_pkg::*;
(
    input  logic [CLS_W-1:0]  cls,
    input  logic [CHK_W-1:0]  chk,
    input  logic [PROP_W-1:0] prop,
    input  logic              tag_a,
    input  logic              tag_b,
    input  logic              tag_addr,
    input  logic              tag_mem,
    output logic              dst,
    output logic              trap
);
    logic                    class_ok;
    logic                    use_mem;
    logic [CHK_FLD-1:0]      ck;
    logic [PROP_FLD-1:0]     pf;
    prop_mode_e              mode;
    logic                    and_sel;
    logic                    chk_opnd;
    logic                    prop_opnd;
    int unsigned             ci;

    always_comb begin
        ci       = 32'(cls);
        class_ok = (ci < NCLASS);
        ck       = '0;
        pf       = '0;
        if (class_ok) begin
            ck = chk[CHK_FLD*ci +: CHK_FLD];
            pf = prop[PROP_FLD*ci +: PROP_FLD];
        end
        mode    = prop_mode_e'(pf[1:0]);
        and_sel = pf[2];

        use_mem   = (cls == OPC_LOAD) || (cls == OPC_FETCH);
        chk_opnd  = use_mem ? tag_mem : (tag_a | tag_b);
        prop_opnd = use_mem ? tag_mem
                            : (and_sel ? (tag_a & tag_b) : (tag_a | tag_b));

        trap = (ck[0] & tag_addr) | (ck[1] & chk_opnd);

        unique case (mode)
            PM_NONE: dst = 1'b0;
            PM_ADDR: dst = tag_addr;
            PM_OPND: dst = prop_opnd;
            PM_BOTH: dst = and_sel ? (tag_addr & prop_opnd)
                                   : (tag_addr | prop_opnd);
            default: dst = 1'b0;
        endcase
    end
endmodule

// File: rtl/taint_rule_unit.sv
module taint_rule_unit
    import taint_pkg::*;
#(
    parameter int NPOL = 4,
    parameter int PC_W = 32,
    localparam int POL_W = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [POL_W-1:0]  cfg_pol,
    input  logic              cfg_kind,
    input  logic [PROP_W-1:0] cfg_data,
    input  logic              op_vld,
    input  logic [CLS_W-1:0]  op_class,
    input  logic [PC_W-1:0]   op_pc,
    input  logic [NPOL-1:0]   src_a_tag,
    input  logic [NPOL-1:0]   src_b_tag,
    input  logic [NPOL-1:0]   addr_tag,
    input  logic [NPOL-1:0]   mem_tag,
    output logic              out_vld,
    output logic [NPOL-1:0]   out_dst_tag,
    output logic [NPOL-1:0]   out_trap,
    output logic [PC_W-1:0]   out_pc
);
    typedef struct packed {
        logic            vld;
        logic [NPOL-1:0] dst;
        logic [NPOL-1:0] trap;
        logic [PC_W-1:0] pc;
    } res_t;

    logic [NPOL-1:0][CHK_W-1:0]  chk_cfg;
    logic [NPOL-1:0][PROP_W-1:0] prop_cfg;
    logic [NPOL-1:0]             dst_c;
    logic [NPOL-1:0]             trap_c;
    res_t                        res_d, res_q;

    taint_cfg_regs #(.NPOL(NPOL)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_pol  (cfg_pol),
        .cfg_kind (cfg_kind),
        .cfg_data (cfg_data),
        .chk_o    (chk_cfg),
        .prop_o   (prop_cfg)
    );

    for (genvar gp = 0; gp < NPOL; gp++) begin : g_pol
        taint_rule_eval u_eval (
            .cls      (op_class),
            .chk      (chk_cfg[gp]),
            .prop     (prop_cfg[gp]),
            .tag_a    (src_a_tag[gp]),
            .tag_b    (src_b_tag[gp]),
            .tag_addr (addr_tag[gp]),
            .tag_mem  (mem_tag[gp]),
            .dst      (dst_c[gp]),
            .trap     (trap_c[gp])
        );
    end

    always_comb begin
        res_d = '0;
        if (op_vld) begin
            res_d.vld  = 1'b1;
            res_d.dst  = dst_c;
            res_d.trap = trap_c;
            res_d.pc   = op_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld     = res_q.vld;
    assign out_dst_tag = res_q.dst;
    assign out_trap    = res_q.trap;
    assign out_pc      = res_q.pc;

    // R9: an idle cycle leaves every result field at zero
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> (out_trap == '0 && out_dst_tag == '0 && !out_vld));
    // R9: the reported pc is the one presented one cycle earlier
    a_r9_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> (out_vld && out_pc == $past(op_pc)));
    // R10: class codes outside the defined set neither trap nor taint
    a_r10_bad_class_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_class >= CLS_W'(NCLASS)) |=> (out_trap == '0 && out_dst_tag == '0));
    // R8: a policy bit cannot trap when none of its own input tags are set
    for (genvar gq = 0; gq < NPOL; gq++) begin : g_pol_asrt
        a_r8_no_tag_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
            (op_vld && !src_a_tag[gq] && !src_b_tag[gq] && !addr_tag[gq] && !mem_tag[gq])
            |=> (!out_trap[gq] && !out_dst_tag[gq]));
    end
endmodule

// File: tb/sim_taint_rule_unit.sv
`timescale 1ns/1ps
module sim_taint_rule_unit;
    localparam int NP = 4;
    localparam int NC = 9;
    localparam int CW = 18;
    localparam int PW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_pol = '0;
    logic          cfg_kind = 1'b0;
    logic [PW-1:0] cfg_data = '0;
    logic          op_vld = 1'b0;
    logic [3:0]    op_class = '0;
    logic [31:0]   op_pc = '0;
    logic [NP-1:0] src_a_tag = '0, src_b_tag = '0, addr_tag = '0, mem_tag = '0;
    logic          out_vld;
    logic [NP-1:0] out_dst_tag, out_trap;
    logic [31:0]   out_pc;

    int checks = 0;
    int fails  = 0;

    logic [CW-1:0] chk_sh  [NP];
    logic [PW-1:0] prop_sh [NP];

    always #2.5 clk = ~clk;

    taint_rule_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pol(cfg_pol),
        .cfg_kind(cfg_kind), .cfg_data(cfg_data), .op_vld(op_vld),
        .op_class(op_class), .op_pc(op_pc), .src_a_tag(src_a_tag),
        .src_b_tag(src_b_tag), .addr_tag(addr_tag), .mem_tag(mem_tag),
        .out_vld(out_vld), .out_dst_tag(out_dst_tag), .out_trap(out_trap),
        .out_pc(out_pc)
    );

    // expected result from the requirements (R3..R8, R10)
    function automatic void model(input logic [3:0] cls, input logic [NP-1:0] a, b, ad, mm,
                                  output logic [NP-1:0] dst, output logic [NP-1:0] trp);
        dst = '0;
        trp = '0;
        for (int p = 0; p < NP; p++) begin
            int c;
            logic ca, cd, an, dopnd, popnd;
            logic [1:0] md;
            c = int'(cls);
            if (c < NC) begin
                ca = chk_sh[p][2*c];
                cd = chk_sh[p][2*c+1];
                md = prop_sh[p][3*c +: 2];
                an = prop_sh[p][3*c+2];
                dopnd = (c == 4 || c == 5) ? mm[p] : (a[p] | b[p]);
                popnd = (c == 4 || c == 5) ? mm[p] : (an ? (a[p] & b[p]) : (a[p] | b[p]));
                trp[p] = (ca && ad[p]) || (cd && dopnd);
                case (md)
                    2'd0: dst[p] = 1'b0;
                    2'd1: dst[p] = ad[p];
                    2'd2: dst[p] = popnd;
                    default: dst[p] = an ? (ad[p] & popnd) : (ad[p] | popnd);
                endcase
            end
        end
    endfunction

    // one cycle: drive on falling edge, compare just after the rising edge
    task automatic step(input string req, input logic we, input logic [1:0] pol,
                        input logic kind, input logic [PW-1:0] data,
                        input logic vld, input logic [3:0] cls, input logic [31:0] pc,
                        input logic [NP-1:0] a, b, ad, mm);
        logic [NP-1:0] e_dst, e_trp;
        logic [31:0]   e_pc;
        @(negedge clk);
        cfg_we = we; cfg_pol = pol; cfg_kind = kind; cfg_data = data;
        op_vld = vld; op_class = cls; op_pc = pc;
        src_a_tag = a; src_b_tag = b; addr_tag = ad; mem_tag = mm;
        model(cls, a, b, ad, mm, e_dst, e_trp);
        if (!vld) begin e_dst = '0; e_trp = '0; e_pc = '0; end
        else e_pc = pc;
        if (we) begin
            if (kind) prop_sh[pol] = data;
            else      chk_sh[pol]  = data[CW-1:0];
        end
        @(posedge clk);
        #1;
        checks++;
        if (out_vld !== vld || out_dst_tag !== e_dst || out_trap !== e_trp || out_pc !== e_pc) begin
            fails++;
            $display("FAIL %s: got vld=%0b dst=%b trap=%b pc=%h, expected vld=%0b dst=%b trap=%b pc=%h",
                     req, out_vld, out_dst_tag, out_trap, out_pc, vld, e_dst, e_trp, e_pc);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) begin chk_sh[p] = '0; prop_sh[p] = '0; end
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_vld !== 1'b0 || out_dst_tag !== '0 || out_trap !== '0 || out_pc !== '0) begin
            fails++;
            $display("FAIL R1: got vld=%0b dst=%b trap=%b pc=%h, expected all zero",
                     out_vld, out_dst_tag, out_trap, out_pc);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: zero config, fully tainted load and arithmetic
        step("R1", 0, 0, 0, '0, 1, 4'd5, 32'h100, 4'hF, 4'hF, 4'hF, 4'hF);
        step("R1", 0, 0, 0, '0, 1, 4'd0, 32'h104, 4'hF, 4'hF, 4'hF, 4'hF);
        // R2/R4: program address check for loads on policy 0, same-cycle op uses old config
        step("R2", 1, 2'd0, 0, 27'(1 << 10), 1, 4'd5, 32'h108, 4'h0, 4'h0, 4'h1, 4'h0);
        step("R4", 0, 0, 0, '0, 1, 4'd5, 32'h10C, 4'h0, 4'h0, 4'h1, 4'h0);
        // R4: operand-only taint on load does not trap with only address check
        step("R4", 0, 0, 0, '0, 1, 4'd5, 32'h110, 4'h0, 4'h0, 4'h0, 4'h1);
        // R4: both checks enabled
        step("R4", 1, 2'd0, 0, 27'(3 << 10), 0, 4'd0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        step("R4", 0, 0, 0, '0, 1, 4'd5, 32'h114, 4'h0, 4'h0, 4'h0, 4'h1);
        // R5/R7: policy 1 load propagation, both mode OR then AND
        step("R5", 1, 2'd1, 1, 27'(3 << 15), 0, 4'd0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        step("R7", 0, 0, 0, '0, 1, 4'd5, 32'h118, 4'h0, 4'h0, 4'h2, 4'h0);
        step("R5", 1, 2'd1, 1, 27'(7 << 15), 0, 4'd0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        step("R7", 0, 0, 0, '0, 1, 4'd5, 32'h11C, 4'h0, 4'h0, 4'h2, 4'h0);
        step("R7", 0, 0, 0, '0, 1, 4'd5, 32'h120, 4'h0, 4'h0, 4'h2, 4'h2);
        // R6: arithmetic operand mode, OR then AND of sources on policy 2
        step("R6", 1, 2'd2, 1, 27'(2), 0, 4'd0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        step("R6", 0, 0, 0, '0, 1, 4'd0, 32'h124, 4'h4, 4'h0, 4'h0, 4'h0);
        step("R6", 1, 2'd2, 1, 27'(6), 1, 4'd0, 32'h128, 4'h4, 4'h0, 4'h0, 4'h0);
        step("R6", 0, 0, 0, '0, 1, 4'd0, 32'h12C, 4'h4, 4'h0, 4'h0, 4'h0);
        // R3: jump target check and syscall argument check on policy 3
        step("R3", 1, 2'd3, 0, 27'((1 << 14) | (1 << 17)), 0, 4'd0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        step("R3", 0, 0, 0, '0, 1, 4'd7, 32'h130, 4'h0, 4'h0, 4'h8, 4'h0);
        step("R3", 0, 0, 0, '0, 1, 4'd8, 32'h134, 4'h0, 4'h8, 4'h0, 4'h0);
        // R8: policy 3 tags do not disturb other policies
        step("R8", 0, 0, 0, '0, 1, 4'd5, 32'h138, 4'h8, 4'h8, 4'h8, 4'h8);
        // R10: undefined classes are inert
        step("R10", 0, 0, 0, '0, 1, 4'd9, 32'h13C, 4'hF, 4'hF, 4'hF, 4'hF);
        step("R10", 0, 0, 0, '0, 1, 4'd15, 32'h140, 4'hF, 4'hF, 4'hF, 4'hF);
        // R9: idle cycle clears outputs
        step("R9", 0, 0, 0, '0, 0, 4'd5, 32'hDEAD, 4'hF, 4'hF, 4'hF, 4'hF);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic we;
            we = ($urandom % 4) == 0;
            step("R7/R8 random", we, 2'($urandom), 1'($urandom),
                 27'($urandom), ($urandom % 8) != 0, 4'($urandom % 12), $urandom,
                 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule